// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block keeps the on/off state of a 12-row by 8-column analog crosspoint matrix. It holds one enable bit per crosspoint, 96 bits in all, and drives them out as a flat vector that the switch fabric uses directly. Software or a sequencer writes the state one cell at a time. It presents a row code, a column code and a data bit, asserts chip select and pulses a write strobe. Only the addressed cell changes. Every other cell keeps its value, so any pattern of connections can be built up, including several rows on one column or one row on several columns.

The design is synchronous to a system clock, and its control inputs arrive already synchronized. A cell is open for writing on every clock edge at which chip select and strobe are both high. While it is open it follows the data input with one clock of latency. The value sampled at the last such edge, just before strobe falls, is the one that stays. The row code space is sparse. Codes 0 to 5 and 8 to 13 map to the twelve rows, and the four remaining codes are dead. A master reset clears the whole memory asynchronously and takes priority over chip select. A combinational readback port returns any single bit so the stored state can be inspected.

Top module: `xbar_ctrl_mem`

## Requirements
- R1: Output bit `switchEn[r*8 + c]` is the enable of row r (0..11), column c (0..7). Row code 0..5 selects rows 0..5 and row code 8..13 selects rows 6..11.
- R2: A cell is written only at a rising clock edge where `chipSel` and `strobe` are both 1. Its output takes `dataIn` one clock after that edge, with 1 meaning on and 0 meaning off.
- R3: While `chipSel` and `strobe` stay high at a fixed address, the cell follows `dataIn` on every clock. After `strobe` falls, the cell keeps the value sampled at the last edge with `strobe` high.
- R4: A write changes no cell other than the addressed one. At most one output bit changes per clock outside reset.
- R5: A write with row code 6, 7, 14 or 15 changes no state.
- R6: The 3-bit column code selects column 0..7 directly, with no gaps.
- R7: `rstAsync` = 1 clears all 96 cells to 0 at once, without waiting for a clock edge, whatever the values of `chipSel`, `strobe` and `dataIn`. No cell is written while it is high.
- R8: Any number of cells may be on at the same time, including a whole column or a whole row.
- R9: `rdBit` returns, combinationally, the stored bit for the row and column codes on `rdRowAddr` and `rdColAddr`, using the same mapping as R1. An invalid row code (6, 7, 14, 15) reads 0.
- R10: After `rstAsync` falls, all cells stay 0 until a qualified write (R2) with `dataIn` = 1.
- R11: If the address changes while `strobe` and `chipSel` stay high, each clock writes only the cell addressed at that edge. A cell that is left keeps the value of the last edge at which it was addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstAsync | input | 1 | Master clear, active high, asynchronous |
| chipSel | input | 1 | Chip select, active high |
| strobe | input | 1 | Write strobe, active high |
| dataIn | input | 1 | Value written into the addressed cell |
| rowAddr | input | 4 | Row code of the write address |
| colAddr | input | 3 | Column code of the write address |
| rdRowAddr | input | 4 | Row code of the readback address |
| rdColAddr | input | 3 | Column code of the readback address |
| rdBit | output | 1 | Stored bit at the readback address |
| switchEn | output | 96 | Crosspoint enables, row-major |

## Verification
The assertions check on every clock that an unqualified write or a dead row code leaves the vector unchanged, and that no more than one bit moves per clock. They also check that a qualified write lands the sampled data in the cell decoded from the past address, that the vector reads all zero during reset, and that the readback matches the vector. Only the bench scenarios can show that reset clears the cells between clock edges, that a value is held across a strobe fall and the idle time after it, that whole columns can be switched on together, and that the memory stays clear after reset until the first real write.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int ROW_AW     = 4;
  localparam int COL_AW     = 3;
  localparam int GROUP_AW   = ROW_AW - 1;
  localparam int GROUP_ROWS = 6;
  localparam int GROUPS     = 1 << (ROW_AW - GROUP_AW);
  localparam int ROWS       = GROUPS * GROUP_ROWS;
  localparam int COLS       = 1 << COL_AW;
  localparam int CELLS      = ROWS * COLS;
  localparam int IDX_W      = $clog2(CELLS);

  typedef struct packed {
    logic             wrEn;
    logic             wrVal;
    logic [IDX_W-1:0] wrIdx;
    logic             rdValid;
    logic [IDX_W-1:0] rdIdx;
  } ctrlStrobes_t;

  function automatic logic rowCodeValid(input logic [ROW_AW-1:0] code);
    return code[GROUP_AW-1:0] < GROUP_AW'(GROUP_ROWS);
  endfunction

  function automatic logic [IDX_W-1:0] cellIndex(input logic [ROW_AW-1:0] code,
                                                 input logic [COL_AW-1:0] col);
    int rowNum;
    rowNum = int'(code[ROW_AW-1:GROUP_AW]) * GROUP_ROWS + int'(code[GROUP_AW-1:0]);
    return IDX_W'(rowNum * COLS + int'(col));
  endfunction
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic              rstAsync,
  input  logic              chipSel,
  input  logic              strobe,
  input  logic              dataIn,
  input  logic [ROW_AW-1:0] rowAddr,
  input  logic [COL_AW-1:0] colAddr,
  input  logic [ROW_AW-1:0] rdRowAddr,
  input  logic [COL_AW-1:0] rdColAddr,
  output ctrlStrobes_t      ctrlOut
);
  logic wrRowOk;
  logic rdRowOk;

  always_comb begin
    wrRowOk = rowCodeValid(rowAddr);
    rdRowOk = rowCodeValid(rdRowAddr);

    ctrlOut.wrEn    = chipSel & strobe & ~rstAsync & wrRowOk;
    ctrlOut.wrVal   = dataIn;
    ctrlOut.wrIdx   = wrRowOk ? cellIndex(rowAddr, colAddr) : '0;
    ctrlOut.rdValid = rdRowOk;
    ctrlOut.rdIdx   = rdRowOk ? cellIndex(rdRowAddr, rdColAddr) : '0;
  end
endmodule

// File: rtl/xbar_store.sv
module xbar_store
  import xbar_pkg::*;
(
  input  logic             clk,
  input  logic             rstAsync,
  input  ctrlStrobes_t     ctrlIn,
  output logic [CELLS-1:0] cellQ,
  output logic             rdBit
);
  for (genvar g = 0; g < CELLS; g++) begin : gCell
    logic cellBit;
    logic hit;
    assign hit = ctrlIn.wrEn && (ctrlIn.wrIdx == IDX_W'(g));
    always_ff @(posedge clk or posedge rstAsync) begin
      if (rstAsync)  cellBit <= 1'b0;
      else if (hit)  cellBit <= ctrlIn.wrVal;
    end
    assign cellQ[g] = cellBit;
  end

  always_comb begin
    rdBit = 1'b0;
    for (int i = 0; i < CELLS; i++) begin
      if (ctrlIn.rdValid && ctrlIn.rdIdx == IDX_W'(i)) rdBit = cellQ[i];
    end
  end
endmodule

// File: rtl/xbar_ctrl_mem.sv
module xbar_ctrl_mem
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstAsync,
  input  logic              chipSel,
  input  logic              strobe,
  input  logic              dataIn,
  input  logic [ROW_AW-1:0] rowAddr,
  input  logic [COL_AW-1:0] colAddr,
  input  logic [ROW_AW-1:0] rdRowAddr,
  input  logic [COL_AW-1:0] rdColAddr,
  output logic              rdBit,
  output logic [CELLS-1:0]  switchEn
);
  ctrlStrobes_t ctrlBus;

  xbar_ctrl uCtrl (
    .rstAsync  (rstAsync),
    .chipSel   (chipSel),
    .strobe    (strobe),
    .dataIn    (dataIn),
    .rowAddr   (rowAddr),
    .colAddr   (colAddr),
    .rdRowAddr (rdRowAddr),
    .rdColAddr (rdColAddr),
    .ctrlOut   (ctrlBus)
  );

  xbar_store uStore (
    .clk      (clk),
    .rstAsync (rstAsync),
    .ctrlIn   (ctrlBus),
    .cellQ    (switchEn),
    .rdBit    (rdBit)
  );
endmodule

// File: rtl/xbar_ctrl_mem_chk.sv
module xbar_ctrl_mem_chk
  import xbar_pkg::*;
(
  input logic              clk,
  input logic              rstAsync,
  input logic              chipSel,
  input logic              strobe,
  input logic              dataIn,
  input logic [ROW_AW-1:0] rowAddr,
  input logic [COL_AW-1:0] colAddr,
  input logic [ROW_AW-1:0] rdRowAddr,
  input logic [COL_AW-1:0] rdColAddr,
  input logic              rdBit,
  input logic [CELLS-1:0]  switchEn
);
  logic pastValid;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) pastValid <= 1'b0;
    else          pastValid <= 1'b1;
  end

  // Independent decode: dead codes return -1.
  function automatic int refCell(input logic [ROW_AW-1:0] code, input logic [COL_AW-1:0] col);
    int r;
    if (code < 6)                    r = int'(code);
    else if (code >= 8 && code < 14) r = int'(code) - 2;
    else                             return -1;
    return r * 8 + int'(col);
  endfunction

  // R7: vector is clear whenever reset is high at an edge
  a_r7_reset_clear: assert property (@(posedge clk) rstAsync |-> switchEn == '0);

  // R2: nothing moves without chip select and strobe
  a_r2_no_unqualified_write: assert property (@(posedge clk) disable iff (rstAsync)
    pastValid && !($past(chipSel) && $past(strobe)) |-> switchEn == $past(switchEn));

  // R5: dead row codes leave state alone
  a_r5_dead_row: assert property (@(posedge clk) disable iff (rstAsync)
    pastValid && refCell($past(rowAddr), $past(colAddr)) < 0 |-> $stable(switchEn));

  // R4: at most one bit moves per clock
  a_r4_single_cell: assert property (@(posedge clk) disable iff (rstAsync)
    pastValid |-> $countones(switchEn ^ $past(switchEn)) <= 1);

  // R3: qualified write lands the sampled data in the decoded cell
  a_r3_follow_data: assert property (@(posedge clk) disable iff (rstAsync)
    pastValid && $past(chipSel) && $past(strobe) && refCell($past(rowAddr), $past(colAddr)) >= 0
    |-> switchEn[refCell($past(rowAddr), $past(colAddr))] == $past(dataIn));

  // R9: readback agrees with the vector
  a_r9_readback: assert property (@(posedge clk) disable iff (rstAsync)
    rdBit == ((refCell(rdRowAddr, rdColAddr) >= 0) ? switchEn[refCell(rdRowAddr, rdColAddr)] : 1'b0));
endmodule

bind xbar_ctrl_mem xbar_ctrl_mem_chk uChk (.*);

// File: tb/xbar_ctrl_mem_test.sv
module xbar_ctrl_mem_test;
  logic        clk = 1'b0;
  logic        rstAsync = 1'b1;
  logic        chipSel = 1'b0, strobe = 1'b0, dataIn = 1'b0;
  logic [3:0]  rowAddr = '0, rdRowAddr = '0;
  logic [2:0]  colAddr = '0, rdColAddr = '0;
  logic        rdBit;
  logic [95:0] switchEn;
  logic [95:0] expVec = '0;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  xbar_ctrl_mem uut (.*);

  function automatic int slotOf(input logic [3:0] code, input logic [2:0] col);
    case (code)
      4'd6, 4'd7, 4'd14, 4'd15: return -1;
      default: return (code[3] ? 6 + int'(code[2:0]) : int'(code[2:0])) * 8 + int'(col);
    endcase
  endfunction

  task automatic checkVec(input string tag);
    checks++;
    if (switchEn !== expVec) begin
      errors++;
      $display("FAIL %s: switchEn=%h expected=%h", tag, switchEn, expVec);
    end
  endtask

  task automatic checkBit(input string tag, input logic got, input logic want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got=%0b expected=%0b", tag, got, want);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input string tag, input logic cs, input logic st, input logic d,
                      input logic [3:0] row, input logic [2:0] col);
    int s;
    chipSel = cs; strobe = st; dataIn = d; rowAddr = row; colAddr = col;
    @(posedge clk);
    s = slotOf(row, col);
    if (!rstAsync && cs && st && s >= 0) expVec[s] = d;
    @(negedge clk);
    checkVec(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkVec("R7 reset state");
    rstAsync = 1'b0;

    // R10: idle after reset, strobe low, stays clear
    for (int i = 0; i < 4; i++) step("R10 idle after reset", 1'b1, 1'b0, 1'b1, 4'(i), 3'(i));

    // R1/R6: corners and mapping
    step("R1 row0 col0", 1, 1, 1, 4'd0, 3'd0);
    checkBit("R1 bit0", switchEn[0], 1'b1);
    step("R1 code13 col7", 1, 1, 1, 4'd13, 3'd7);
    checkBit("R1 bit95", switchEn[95], 1'b1);
    step("R1 code8 col0", 1, 1, 1, 4'd8, 3'd0);
    checkBit("R1 row6 bit48", switchEn[48], 1'b1);
    step("R6 code5 col3", 1, 1, 1, 4'd5, 3'd3);
    checkBit("R6 bit43", switchEn[43], 1'b1);
    step("R2 strobe off", 1, 0, 0, 4'd0, 3'd0);

    // R5: dead row codes
    foreach (expVec[k]) ; // no-op keeps model untouched
    for (int c = 0; c < 8; c++) begin
      step("R5 code6", 1, 1, 1, 4'd6, 3'(c));
      step("R5 code7", 1, 1, 1, 4'd7, 3'(c));
      step("R5 code14", 1, 1, 1, 4'd14, 3'(c));
      step("R5 code15", 1, 1, 1, 4'd15, 3'(c));
    end

    // R3: tracking while strobe high, then hold after fall
    step("R3 track 1", 1, 1, 1, 4'd2, 3'd4);
    step("R3 track 0", 1, 1, 0, 4'd2, 3'd4);
    step("R3 track 1 again", 1, 1, 1, 4'd2, 3'd4);
    step("R3 strobe fall", 1, 0, 0, 4'd2, 3'd4);
    step("R3 hold idle", 1, 0, 0, 4'd2, 3'd4);
    checkBit("R3 retained", switchEn[2*8+4], 1'b1);

    // R2: chip select low blocks the write
    step("R2 cs low", 0, 1, 1, 4'd3, 3'd1);
    checkBit("R2 cs low bit", switchEn[3*8+1], 1'b0);

    // R11: address walks while strobe held high
    step("R11 walk a", 1, 1, 1, 4'd9, 3'd2);
    step("R11 walk b", 1, 1, 1, 4'd9, 3'd3);
    step("R11 walk c", 1, 1, 0, 4'd9, 3'd4);
    step("R11 walk d", 1, 1, 0, 4'd9, 3'd2);
    step("R11 end", 1, 0, 1, 4'd9, 3'd2);
    checkBit("R11 left cell kept", switchEn[7*8+3], 1'b1);

    // R8: whole column 5 on
    for (int r = 0; r < 16; r++) step("R8 column fill", 1, 1, 1, 4'(r), 3'd5);
    checks++;
    if ($countones(switchEn & {12{8'b0010_0000}}) != 12) begin
      errors++;
      $display("FAIL R8: column5 on=%0d expected=12", $countones(switchEn & {12{8'b0010_0000}}));
    end

    // R9: readback over every code, dead codes read 0
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++) begin
        int s;
        rdRowAddr = 4'(r); rdColAddr = 3'(c);
        #1;
        s = slotOf(4'(r), 3'(c));
        checkBit("R9 readback", rdBit, s >= 0 ? expVec[s] : 1'b0);
      end

    // R7: async clear between edges with writes attempted
    chipSel = 1; strobe = 1; dataIn = 1; rowAddr = 4'd1; colAddr = 3'd1;
    #1 rstAsync = 1'b1;
    #1;
    expVec = '0;
    checkVec("R7 async clear");
    @(negedge clk);
    step("R7 held no write", 1, 1, 1, 4'd1, 3'd1);
    chipSel = 0; strobe = 0;
    rstAsync = 1'b0;
    step("R10 after release", 0, 0, 1, 4'd1, 3'd1);

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic cs, st, d;
      cs = ($urandom % 4) != 0;
      st = ($urandom % 2) != 0;
      d  = ($urandom % 2) != 0;
      step("R2/R4 random", cs, st, d, 4'($urandom % 16), 3'($urandom % 8));
      if (i % 97 == 0) begin
        int s;
        rdRowAddr = 4'($urandom % 16); rdColAddr = 3'($urandom % 8);
        #1;
        s = slotOf(rdRowAddr, rdColAddr);
        checkBit("R9 random readback", rdBit, s >= 0 ? expVec[s] : 1'b0);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule